// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

The block turns one byte at a time into an asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. An 8-bit line-control value sets the frame shape: how many data bits are sent, whether a parity bit is added and of which kind, and how long the stop interval lasts. Bit timing comes from an enable pulse that runs at sixteen times the bit rate. The block does not generate that pulse itself.

A state machine steps through five named states. In `ST_IDLE` the line is high and a byte can be accepted. `ST_START` sends the low start bit. `ST_DATA` sends the data bits. `ST_PARITY` is entered only when parity is enabled. `ST_STOP` sends the high stop interval. The transitions are as follows:
- IDLE→START on an accepted byte.
- START→DATA at the end of the start bit.
- DATA→PARITY or DATA→STOP after the last data bit, depending on whether parity is on.
- PARITY→STOP after the parity bit.
- STOP→IDLE when the stop interval expires.

The frame format is captured when the byte is accepted and stays fixed for the rest of that frame. Two control bits act live instead of per frame. The break bit pulls the line low whenever it is set. The top control bit appears on a status output and has no effect on framing.

Top module: `uart_tx_framer`

## Requirements
- R1: The line idles high with `busy_o`=0 and `tx_ready_o`=1. A byte is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` stays low and `busy_o` stays high from the edge after acceptance until the frame ends.
- R2: A frame begins with one low start bit, then sends the data bits least-significant first. Every bit lasts exactly 16 baud ticks, and the state does not advance on cycles without a tick.
- R3: Control bits [1:0] choose the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: Control bit 3 set adds one parity bit after the data. With bit 5 clear, bit 4=1 gives even parity and bit 4=0 gives odd parity. With bit 3 clear, no parity bit is sent.
- R5: With bit 3 and bit 5 both set, the parity bit is a constant. It is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R6: Control bit 2 clear gives a stop interval of 16 ticks. Bit 2 set gives 24 ticks with 5 data bits and 32 ticks with 6, 7 or 8 data bits. The line is high throughout the stop interval, and `busy_o` falls exactly when it ends.
- R7: Control bit 6 set drives the line low immediately and for as long as the bit is set. Clearing it gives the line back to the frame logic, which is high when idle.
- R8: Control bit 7 is mirrored on `dlab_o` and does not change the frame.
- R9: The format is sampled on the acceptance edge. A change to the control value during a frame does not affect that frame.
- R10: Data bits above the configured length are not sent, and they do not contribute to computed parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Enable pulse at 16x bit rate |
| ctl_i | input | 8 | Line-control value |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte can be accepted |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |
| dlab_o | output | 1 | Mirror of control bit 7 |

## Verification
The start bit appears on the serial line on the first edge after acceptance, and `tx_ready_o` drops on that same edge. After that, each bit level holds for 16 counted ticks. The bench therefore counts baud ticks as the design sees them at rising edges, from the acceptance edge onward. It samples each bit at the falling edge after its eighth tick, and it checks `busy_o` one tick before and one tick after the expected stop end. The break and `dlab_o` paths are combinational, so they are checked at the next falling edge after the control value changes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned BYTE_W = 8;

    // Control-bit positions (they select behaviour, so the positions are fixed)
    localparam int unsigned CTL_STOP  = 2;
    localparam int unsigned CTL_PAR   = 3;
    localparam int unsigned CTL_EVEN  = 4;
    localparam int unsigned CTL_STICK = 5;
    localparam int unsigned CTL_BRK   = 6;
    localparam int unsigned CTL_DLAB  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       stop_ext;
        logic       par_on;
        logic       par_even;
        logic       par_stick;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [BYTE_W-1:0] ctl);
        frame_fmt_t f;
        f.len_code  = ctl[1:0];
        f.stop_ext  = ctl[CTL_STOP];
        f.par_on    = ctl[CTL_PAR];
        f.par_even  = ctl[CTL_EVEN];
        f.par_stick = ctl[CTL_STICK];
        return f;
    endfunction

    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] len_code);
        return 8'hFF >> (2'd3 - len_code);
    endfunction

    function automatic logic calc_parity(input logic [BYTE_W-1:0] masked,
                                         input frame_fmt_t f);
        if (f.par_stick)
            return !f.par_even;
        return f.par_even ? ^masked : ~^masked;
    endfunction

endpackage

// File: rtl/uart_tx_fmt_reg.sv
module uart_tx_fmt_reg
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] ctl_i,
    input  logic [BYTE_W-1:0] data_i,
    output frame_fmt_t        fmt_o,
    output logic              par_o,
    output logic [BYTE_W-1:0] masked_o
);
    frame_fmt_t live_fmt;

    always_comb begin
        live_fmt = decode_fmt(ctl_i);
        masked_o = data_i & len_mask(live_fmt.len_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_o <= '0;
            par_o <= 1'b0;
        end else if (load) begin
            fmt_o <= live_fmt;
            par_o <= calc_parity(masked_o, live_fmt);
        end
    end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             phase_end
);
    logic [CNT_W-1:0] cnt_q;

    assign phase_end = tick && !clear && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || phase_end)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb_o
);
    logic [WIDTH-1:0] sr_q;

    assign lsb_o = sr_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= din;
        else if (shift)
            sr_q <= {1'b0, sr_q[WIDTH-1:1]};
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick_i,
    input  logic [BYTE_W-1:0] ctl_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              tx_o,
    output logic              busy_o,
    output logic              dlab_o
);
    localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT) + 1;
    localparam logic [CNT_W-1:0] T_ONE   = CNT_W'(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] T_ONEHF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CNT_W-1:0] T_TWO   = CNT_W'(2 * TICKS_PER_BIT);

    tx_state_t        state_q, state_d;
    frame_fmt_t       fmt_q;
    logic             par_q, data_bit, phase_end, accept, last_bit, line;
    logic [2:0]       bit_idx_q;
    logic [CNT_W-1:0] limit;
    logic [BYTE_W-1:0] masked;

    assign accept   = (state_q == ST_IDLE) && tx_valid_i;
    assign last_bit = (bit_idx_q == 3'd4 + {1'b0, fmt_q.len_code});

    uart_tx_fmt_reg fmt_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .ctl_i(ctl_i),
        .data_i(tx_data_i), .fmt_o(fmt_q), .par_o(par_q), .masked_o(masked)
    );

    uart_tx_shifter #(.WIDTH(BYTE_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .shift(state_q == ST_DATA && phase_end), .din(masked), .lsb_o(data_bit)
    );

    uart_tx_bit_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
        .tick(baud_tick_i), .limit(limit), .phase_end(phase_end)
    );

    always_comb begin
        if (state_q == ST_STOP && fmt_q.stop_ext)
            limit = (fmt_q.len_code == 2'b00) ? T_ONEHF : T_TWO;
        else
            limit = T_ONE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_START)
                bit_idx_q <= '0;
            else if (state_q == ST_DATA && phase_end)
                bit_idx_q <= bit_idx_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_START;
            ST_START:  if (phase_end) state_d = ST_DATA;
            ST_DATA:   if (phase_end && last_bit)
                           state_d = fmt_q.par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (phase_end) state_d = ST_STOP;
            ST_STOP:   if (phase_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = data_bit;
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
        tx_o       = ctl_i[CTL_BRK] ? 1'b0 : line;
        busy_o     = (state_q != ST_IDLE);
        tx_ready_o = (state_q == ST_IDLE);
        dlab_o     = ctl_i[CTL_DLAB];
    end
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick_i,
    input logic [7:0] ctl_i,
    input logic       tx_valid_i,
    input logic       tx_ready_o,
    input logic       tx_o,
    input logic       busy_o
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> (busy_o && !tx_ready_o && (!tx_o || ctl_i[6])));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ctl_i[6]) |-> tx_o);

    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i[6] |-> !tx_o);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !baud_tick_i) |=> busy_o);

    assert_end_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(baud_tick_i));
endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .baud_tick_i(baud_tick_i), .ctl_i(ctl_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_o(tx_o), .busy_o(busy_o)
);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] ctl = 8'h03;
    logic [7:0] data = 8'h00;
    logic       valid = 1'b0;
    logic       ready, tx, busy, dlab;

    always #10 clk = ~clk;

    uart_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick_i(tick), .ctl_i(ctl),
        .tx_data_i(data), .tx_valid_i(valid), .tx_ready_o(ready),
        .tx_o(tx), .busy_o(busy), .dlab_o(dlab)
    );

    typedef struct {
        logic [11:0] bits;
        int          nb;
        int          stop_t;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0, fails = 0, sent = 0, done = 0, tick_div = 1, tick_ph = 0;

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
        tick = (tick_ph == 0);
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic exp_t build(input logic [7:0] d, input logic [7:0] c, input string tag);
        exp_t e;
        int   wl = 5 + int'(c[1:0]);
        logic p = 1'b0;
        e.bits = '0;
        for (int i = 0; i < wl; i++) begin
            e.bits[i] = d[i];
            p ^= d[i];
        end
        e.nb = wl;
        if (c[3]) begin
            if (c[5]) e.bits[wl] = !c[4];
            else      e.bits[wl] = c[4] ? p : !p;
            e.nb = wl + 1;
        end
        e.stop_t = !c[2] ? 16 : (wl == 5 ? 24 : 32);
        e.tag = tag;
        return e;
    endfunction

    task automatic wait_ticks(input int k);
        int c = 0;
        while (c < k) begin
            @(posedge clk);
            if (tick) c++;
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [7:0] c, input string tag);
        do @(negedge clk); while (!ready);
        ctl = c; data = d; valid = 1'b1;
        q.push_back(build(d, c, tag));
        sent++;
        @(negedge clk);
        valid = 1'b0;
        data = ~d;
        check(!ready && busy, {"R1 accept ", tag}, {ready, busy}, 2'b01);
    endtask

    // Monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && busy && !tx) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected frame", 1, 0);
                end else begin
                    e = q.pop_front();
                    wait_ticks(8); @(negedge clk);
                    check(tx == 1'b0, {"R2 start ", e.tag}, tx, 0);
                    for (int i = 0; i < e.nb; i++) begin
                        wait_ticks(16); @(negedge clk);
                        check(tx == e.bits[i], {"R3/R4/R5/R10 bit ", e.tag}, tx, e.bits[i]);
                    end
                    wait_ticks(16); @(negedge clk);
                    check(tx == 1'b1, {"R6 stop level ", e.tag}, tx, 1);
                    wait_ticks(e.stop_t - 9); @(negedge clk);
                    check(busy == 1'b1, {"R6 stop not early ", e.tag}, busy, 1);
                    wait_ticks(1); @(negedge clk);
                    check(!busy && ready && tx, {"R6 stop end ", e.tag}, {busy, ready, tx}, 3'b011);
                end
                done++;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx && !busy && ready, "R1 reset state", {tx, busy, ready}, 3'b101);
        rst_n = 1'b1;
        send(8'hA5, 8'h03, "R3 8N1");
        send(8'h3C, 8'h1B, "R4 8 even");
        send(8'h3D, 8'h0B, "R4 8 odd");
        send(8'hE5, 8'h04, "R6 R10 5-bit 1.5stop");
        send(8'h2A, 8'h05, "R6 6-bit 2stop");
        send(8'h7F, 8'h2A, "R5 7-bit stick1");
        send(8'h00, 8'h3A, "R5 7-bit stick0");
        send(8'hF1, 8'h0C, "R10 5-bit odd masked");
        send(8'h55, 8'h83, "R8 dlab frame");
        check(dlab == 1'b1, "R8 dlab set", dlab, 1);
        wait (done == sent);
        tick_div = 3;
        send(8'h96, 8'h03, "R2 sparse ticks");
        wait (done == sent);
        tick_div = 1;
        send(8'h0F, 8'h03, "R9 latched fmt");
        ctl = 8'h0C;
        wait (done == sent);
        @(negedge clk);
        ctl = 8'h03;
        @(negedge clk);
        check(dlab == 1'b0, "R8 dlab clear", dlab, 0);
        ctl = 8'h43;
        @(negedge clk);
        check(!tx && !busy, "R7 break low", {tx, busy}, 2'b00);
        repeat (20) @(negedge clk);
        check(!tx, "R7 break held", tx, 0);
        ctl = 8'h03;
        @(negedge clk);
        check(tx && ready, "R7 break released", {tx, ready}, 2'b11);
        check(q.size() == 0, "R1 queue drained", q.size(), 0);
        summary();
    end
endmodule